// File: doc/BRIEF.md
# Activity Watchdog Timer

This block watches a one-bit hardware activity strobe. While it is enabled, a down counter runs from a programmable timeout value. Each activity pulse reloads the counter, so a healthy system never lets it run out. When the counter does run out, the block raises an interrupt. The interrupt stays raised until software clears it. If the interrupt is still pending when the next full timeout period ends, the block drives a system reset pulse of fixed length.

Software reaches the block through a single-cycle register bus made of an address, write data and a write enable. Read data comes from a register one clock after the address is presented. The bus can set the enable bit, program the timeout length, read the pending interrupt and clear it. Clearing the enable bit freezes the counter and silences both outputs.

Top module: `activity_watchdog`

## Requirements
- R1: After synchronous reset, `irq` and `sys_rst_out` are low, the control register reads 0 and the timeout register reads the parameter `TMO_INIT`.
- R2: The register map is as follows. Address 0 is control, with bit 0 as the enable. Address 1 holds the timeout value, zero-extended on read. Address 2 is status, with bit 0 for the pending interrupt and bit 1 for the active reset pulse. Address 3 reads 0 and ignores writes. Unused bits read 0. `bus_rdata` shows the register selected by `bus_addr` in the cycle after that address is presented.
- R3: A control write that sets the enable while it was clear loads the counter with the timeout value T. With no activity, `irq` goes high T+1 clocks after the edge that takes the enabling write.
- R4: While enabled, an `activity` high at a clock edge reloads the counter with T and never raises `irq` at that edge. Activity pulses spaced at most T+1 clocks apart keep `irq` low. After the last pulse, `irq` rises T+1 clocks later.
- R5: `irq` stays high until software writes status with bit 0 = 1, which drops it at that edge. If an expiry falls on the same edge as the clear, the expiry wins.
- R6: An expiry reloads the counter. When an expiry occurs while `irq` is already set, `sys_rst_out` goes high at that edge for exactly `PULSE_CYC` clocks. With no activity this happens 2T+2 clocks after enabling.
- R7: If `irq` is cleared before the second expiry, no reset pulse is produced, and that expiry sets `irq` again.
- R8: A control write with bit 0 = 0 drops `irq` and `sys_rst_out` at that edge, and both stay low while the block is disabled.
- R9: A new timeout value written during a count takes effect only at the next reload. The count already running finishes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_rdata | output | DATA_W | Registered read data |
| activity | input | 1 | Activity strobe that restarts the count |
| irq | output | 1 | Timeout interrupt |
| sys_rst_out | output | 1 | System reset pulse |

## Verification
The bench builds the block with `TMO_INIT` = 20, `PULSE_CYC` = 16 and 16-bit data and timeout fields. It then programs timeouts of 5 and 20 cycles. These short periods put every expiry, the second-expiry reset pulse and its exact 16-cycle width within a few dozen clocks. A 20-cycle timeout keeps the reset pulse from overlapping the next expiry, while a 5-cycle timeout lets a clear arrive between two expiries. Changing the timeout mid-count from 5 to 20 makes the old and new periods land on clearly different cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_TMO  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TMO_W    = 16,
  parameter int TMO_INIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire,
  input  logic              pulse_on,
  output logic              en,
  output logic              start,
  output logic              kill,
  output logic [TMO_W-1:0]  tmo,
  output logic              irq_flag
);
  logic wr_ctrl, wr_tmo, wr_stat;

  assign wr_ctrl = bus_we && (bus_addr == REG_CTRL);
  assign wr_tmo  = bus_we && (bus_addr == REG_TMO);
  assign wr_stat = bus_we && (bus_addr == REG_STAT);
  assign start   = wr_ctrl && bus_wdata[0] && !en;
  assign kill    = wr_ctrl && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      tmo      <= TMO_W'(TMO_INIT);
      irq_flag <= 1'b0;
    end else begin
      if (wr_ctrl) en <= bus_wdata[0];
      if (wr_tmo)  tmo <= bus_wdata[TMO_W-1:0];
      if (kill)
        irq_flag <= 1'b0;
      else if (expire)
        irq_flag <= 1'b1;
      else if (wr_stat && bus_wdata[0])
        irq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        REG_CTRL: bus_rdata <= DATA_W'(en);
        REG_TMO:  bus_rdata <= DATA_W'(tmo);
        REG_STAT: bus_rdata <= DATA_W'({pulse_on, irq_flag});
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             activity,
  input  logic [TMO_W-1:0] tmo,
  output logic             expire
);
  logic [TMO_W-1:0] count;
  logic             reload;

  assign reload = start || (en && activity);
  assign expire = en && !reload && (count == '0);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (reload || expire)
      count <= tmo;
    else if (en)
      count <= count - 1'b1;
  end
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  input  logic kill,
  output logic pulse
);
  localparam int CW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (trigger) begin
      pulse <= 1'b1;
      left  <= CW'(PULSE_CYC - 1);
    end else if (pulse) begin
      if (left == '0)
        pulse <= 1'b0;
      else
        left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
  import wdog_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TMO_W     = 16,
  parameter int TMO_INIT  = 1000,
  parameter int PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              activity,
  output logic              irq,
  output logic              sys_rst_out
);
  logic             en, start, kill, expire, irq_flag, pulse;
  logic [TMO_W-1:0] tmo;

  wdog_regs #(
    .DATA_W(DATA_W), .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata),
    .expire(expire), .pulse_on(pulse),
    .en(en), .start(start), .kill(kill), .tmo(tmo), .irq_flag(irq_flag)
  );

  wdog_downcount #(.TMO_W(TMO_W)) u_count (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .activity(activity), .tmo(tmo), .expire(expire)
  );

  wdog_rst_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
    .clk(clk), .rst(rst),
    .trigger(expire && irq_flag), .kill(kill), .pulse(pulse)
  );

  assign irq         = irq_flag;
  assign sys_rst_out = pulse;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              activity,
  input logic              en,
  input logic              expire,
  input logic              irq,
  input logic              sys_rst_out
);
  logic clr_wr, off_wr;
  assign clr_wr = bus_we && (bus_addr == 2'd2) && bus_wdata[0];
  assign off_wr = bus_we && (bus_addr == 2'd0) && !bus_wdata[0];

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!irq && !sys_rst_out));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !expire) |=> !irq);

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr && !off_wr) |=> irq);

  // R4
  activity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && activity) |=> !$rose(irq));

  // R6
  pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_out) |-> $past(irq));
endmodule

bind activity_watchdog wdog_chk #(.DATA_W(DATA_W)) u_wdog_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .activity(activity), .en(en), .expire(expire),
  .irq(irq), .sys_rst_out(sys_rst_out)
);

// File: tb/activity_watchdog_bench.sv
module activity_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          activity = 1'b0;
  logic          irq, sys_rst_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  activity_watchdog #(
    .DATA_W(DW), .TMO_W(16), .TMO_INIT(20), .PULSE_CYC(16)
  ) u_activity_watchdog (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .activity(activity),
    .irq(irq), .sys_rst_out(sys_rst_out)
  );

  typedef struct packed {
    logic          we;
    logic [1:0]    addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 2'd1, 16'h00AB, 16'h00AB},
    '{1'b1, 2'd1, 16'hFFFF, 16'hFFFF},
    '{1'b1, 2'd3, 16'h1234, 16'h0000},
    '{1'b0, 2'd0, 16'h0000, 16'h0000},
    '{1'b1, 2'd0, 16'hFFFE, 16'h0000},
    '{1'b1, 2'd2, 16'h0001, 16'h0000},
    '{1'b1, 2'd1, 16'h0007, 16'h0007},
    '{1'b0, 2'd2, 16'h0000, 16'h0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, logic [DW-1:0] exp, string req);
    bus_addr = a;
    tick();
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", DW'(irq), 0);
    chk("R1 sys_rst_out", DW'(sys_rst_out), 0);
    rd(2'd0, 16'h0000, "R1 ctrl");
    rd(2'd1, 16'd20, "R1 timeout");

    // R2 register table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].wdata);
      rd(VEC[i].addr, VEC[i].exp, "R2 table");
    end

    // R3 / R6 / R5: T=20, no activity
    wr(2'd1, 16'd20);
    wr(2'd0, 16'd1);
    repeat (20) tick();
    chk("R3 irq before expiry", DW'(irq), 0);
    tick();
    chk("R3 irq at T+1", DW'(irq), 1);
    repeat (20) tick();
    chk("R6 no pulse before 2T+2", DW'(sys_rst_out), 0);
    tick();
    chk("R6 pulse at 2T+2", DW'(sys_rst_out), 1);
    repeat (15) tick();
    chk("R6 pulse last cycle", DW'(sys_rst_out), 1);
    tick();
    chk("R6 pulse ended", DW'(sys_rst_out), 0);
    chk("R5 irq still pending", DW'(irq), 1);
    // R8 disable
    wr(2'd0, 16'd0);
    chk("R8 irq dropped", DW'(irq), 0);
    chk("R8 pulse dropped", DW'(sys_rst_out), 0);
    repeat (30) tick();
    chk("R8 irq stays low", DW'(irq), 0);
    chk("R8 pulse stays low", DW'(sys_rst_out), 0);

    // R5 / R7: T=5, clear between expiries
    wr(2'd1, 16'd5);
    wr(2'd0, 16'd1);
    repeat (6) tick();
    chk("R3 irq at T+1 (T=5)", DW'(irq), 1);
    wr(2'd2, 16'd1);
    chk("R5 clear drops irq", DW'(irq), 0);
    repeat (4) tick();
    chk("R7 irq low before second expiry", DW'(irq), 0);
    tick();
    chk("R7 irq set again", DW'(irq), 1);
    chk("R7 no pulse", DW'(sys_rst_out), 0);
    tick();
    chk("R7 no pulse later", DW'(sys_rst_out), 0);
    wr(2'd0, 16'd0);

    // R4 activity keeps irq low
    wr(2'd0, 16'd1);
    for (int k = 0; k < 10; k++) begin
      repeat (3) tick();
      activity = 1'b1;
      tick();
      activity = 1'b0;
    end
    chk("R4 irq low under activity", DW'(irq), 0);
    repeat (5) tick();
    chk("R4 irq low before T+1 after last pulse", DW'(irq), 0);
    tick();
    chk("R4 irq at T+1 after last pulse", DW'(irq), 1);
    wr(2'd0, 16'd0);

    // R9 timeout change mid-count
    wr(2'd1, 16'd5);
    wr(2'd0, 16'd1);
    tick();
    wr(2'd1, 16'd20);
    repeat (3) tick();
    chk("R9 irq low before old expiry", DW'(irq), 0);
    tick();
    chk("R9 old timeout used", DW'(irq), 1);
    repeat (20) tick();
    chk("R9 no pulse before new period", DW'(sys_rst_out), 0);
    tick();
    chk("R9 new timeout used at reload", DW'(sys_rst_out), 1);
    rd(2'd2, 16'h0003, "R2 status shows irq and pulse");
    wr(2'd0, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule